// File: doc/BRIEF.md
# SDRAM Bank State and Timing Monitor

This block watches the command pins of a four-bank synchronous DRAM without driving anything onto them. On every rising clock edge it decodes the command that the memory controller presents and keeps a model of the memory's bank state. For each bank it records whether a row is open, which row that is, how many clocks have passed since the bank was last activated, and how many have passed since it last closed. It also keeps one clock count since the most recent activate to any bank.

The bank model covers three ways a bank can close. A precharge can target a single bank, or it can target all banks at once. A read or write can also request closure after its burst, and the block then closes that bank by itself. Each decoded command is checked against the minimum spacing rules, and the block also reports column access to an idle bank and activation of a bank that is already open. A violation produces a one-cycle pulse with a numeric reason code on the clock after the offending command. The model then takes up the command anyway, so that it follows what the memory itself would do.

The block has no data path. All ports are plain control and status pins with no handshake, so there is no back-pressure to respect. The monitor can never stall the bus it observes.

Top module: `sdram_bank_monitor`

## Requirements
- R1: A command is taken only when `cs_n` is low and `cke` is high at the clock edge. Inside that, the value {`ras_n`,`cas_n`,`we_n`} selects the command: 3'b011 is activate, 3'b101 is read, 3'b100 is write and 3'b010 is precharge. Every other value, and every edge where the command is not taken, changes no bank state and raises no error.
- R2: An activate sets `bank_open[ba]`, effective after the edge. It stores `addr` as the open row of that bank, which appears on `open_rows[ba*ADDR_W +: ADDR_W]`.
- R3: A precharge with `addr[10]` low closes only bank `ba`. A precharge with `addr[10]` high closes all banks, whatever the value of `ba`.
- R4: A read or write to an open bank with `addr[10]` high closes that bank `AP_DELAY` clocks after the command (one clock by default). The bank still counts as open at the command edge and up to that later edge. The precharge-to-activate count starts at the edge where it closes.
- R5: A read or write to a bank that is not open raises error code 1.
- R6: A read or write issued fewer than `T_RCD` clocks (default 3) after that bank's activate raises error code 2.
- R7: A precharge that closes any open bank activated fewer than `T_RAS` clocks (default 5) earlier raises error code 3. This applies to single-bank and all-bank forms alike.
- R8: An activate to a closed bank raises error code 4 in either of two cases: the bank closed fewer than `T_RP` clocks (default 3) earlier, or its previous activate was fewer than `T_RC` clocks (default 8) earlier.
- R9: An activate issued fewer than `T_RRD` clocks (default 2) after the activate of any other bank raises error code 5.
- R10: An activate to a bank that is already open raises error code 6. When several activate rules fail at once, code 6 takes precedence over 4, and 4 over 5.
- R11: `err_pulse` and `err_code` are registered: they show the result of the command sampled at one edge during the following cycle. `err_code` is 0 whenever `err_pulse` is low. Reads and writes to an open bank past `T_RCD` may follow each other on every clock without error.
- R12: The bank model applies every decoded command, including one that raised an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge used |
| rst_n | input | 1 | Active-low synchronous reset; all banks idle, all counts saturated |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; commands ignored while low |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (12) | Row address on activate; bit 10 selects auto/all-bank close |
| bank_open | output | NUM_BANKS (4) | One bit per bank, high while a row is open |
| open_rows | output | NUM_BANKS*ADDR_W (48) | Row last opened in each bank, bank 0 in the low bits |
| err_pulse | output | 1 | High for one cycle after a violating command |
| err_code | output | 3 | Violation reason, 1 to 6; 0 when no error |

## Verification
Two events can land on the same edge: the delayed closure that follows a read or write with `addr[10]` high, and a new command to the same bank on the very next clock. The bench provokes this in two ways. It issues an activate one clock after such a read, which must report code 6 because the bank is still open at that edge. It also issues a plain read at that clock, which must pass without error, and the bench then checks that the bank reads back as closed. A sweep over the gap between that read and a later activate checks that the precharge-to-activate count starts at the closing edge and not at the read.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_OTHER = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_CLOSED = 3'd1,
    ERR_RCD    = 3'd2,
    ERR_RAS    = 3'd3,
    ERR_RP_RC  = 3'd4,
    ERR_RRD    = 3'd5,
    ERR_REOPEN = 3'd6
  } err_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic cke,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n && cke) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b111:  cmd = CMD_NOP;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int ROW_W    = 12,
  parameter int CNT_W    = 4,
  parameter int AP_DELAY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             ap_arm_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [CNT_W-1:0] act_age_o,
  output logic [CNT_W-1:0] close_age_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int AP_W = $clog2(AP_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [AP_W-1:0]  AP_LOAD = AP_W'(AP_DELAY);
  localparam logic [AP_W-1:0]  AP_ONE  = AP_W'(1);

  logic [AP_W-1:0] ap_cnt;
  logic            auto_close;
  logic            closing;

  assign auto_close = (ap_cnt == AP_ONE);
  assign closing    = !act_i && open_o && (close_i || auto_close);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o      <= 1'b0;
      row_o       <= '0;
      act_age_o   <= CNT_SAT;
      close_age_o <= CNT_SAT;
      ap_cnt      <= '0;
    end else begin
      if (act_i)                   act_age_o <= CNT_ONE;
      else if (act_age_o != CNT_SAT) act_age_o <= act_age_o + CNT_ONE;

      if (closing)                     close_age_o <= CNT_ONE;
      else if (close_age_o != CNT_SAT) close_age_o <= close_age_o + CNT_ONE;

      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
        ap_cnt <= '0;
      end else if (close_i || auto_close) begin
        open_o <= 1'b0;
        ap_cnt <= '0;
      end else if (ap_arm_i) begin
        ap_cnt <= AP_LOAD;
      end else if (ap_cnt != '0) begin
        ap_cnt <= ap_cnt - AP_ONE;
      end
    end
  end

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int CNT_W     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  parameter int T_RRD     = 2
) (
  input  cmd_e                            cmd,
  input  logic [BA_W-1:0]                 ba,
  input  logic                            ap,
  input  logic [NUM_BANKS-1:0]            open_vec,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] act_age,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] close_age,
  input  logic [CNT_W-1:0]                rrd_age,
  output err_e                            err
);

  localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] LIM_RRD = CNT_W'(T_RRD);

  always_comb begin
    err = ERR_NONE;
    case (cmd)
      CMD_RD, CMD_WR: begin
        if (!open_vec[ba])              err = ERR_CLOSED;
        else if (act_age[ba] < LIM_RCD) err = ERR_RCD;
      end
      CMD_PRE: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (open_vec[b] && (ap || (ba == BA_W'(b))) && (act_age[b] < LIM_RAS))
            err = ERR_RAS;
        end
      end
      CMD_ACT: begin
        if (open_vec[ba])
          err = ERR_REOPEN;
        else if ((close_age[ba] < LIM_RP) || (act_age[ba] < LIM_RC))
          err = ERR_RP_RC;
        else if (rrd_age < LIM_RRD)
          err = ERR_RRD;
      end
      default: err = ERR_NONE;
    endcase
  end

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  parameter int T_RRD     = 2,
  parameter int AP_DELAY  = 1,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic                        cke,
  input  logic [BA_W-1:0]             ba,
  input  logic [ADDR_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]        bank_open,
  output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
  output logic                        err_pulse,
  output logic [2:0]                  err_code
);

  localparam int T_MAX = imax(imax(imax(T_RC, T_RAS), imax(T_RP, T_RCD)), T_RRD);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  cmd_e                            cmd;
  err_e                            err_now;
  logic                            ap_flag;
  logic [CNT_W-1:0]                rrd_age;
  logic [NUM_BANKS-1:0][CNT_W-1:0] act_age;
  logic [NUM_BANKS-1:0][CNT_W-1:0] close_age;

  assign ap_flag = addr[AP_BIT];

  sdram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .cke   (cke),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    logic act_g;
    logic close_g;
    logic arm_g;

    assign sel     = (ba == BA_W'(g));
    assign act_g   = (cmd == CMD_ACT) && sel;
    assign close_g = (cmd == CMD_PRE) && (ap_flag || sel);
    assign arm_g   = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel && ap_flag && bank_open[g];

    sdram_bank_track #(
      .ROW_W    (ADDR_W),
      .CNT_W    (CNT_W),
      .AP_DELAY (AP_DELAY)
    ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act_g),
      .close_i     (close_g),
      .ap_arm_i    (arm_g),
      .row_i       (addr),
      .open_o      (bank_open[g]),
      .act_age_o   (act_age[g]),
      .close_age_o (close_age[g]),
      .row_o       (open_rows[g*ADDR_W +: ADDR_W])
    );
  end

  sdram_rule_check #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .CNT_W     (CNT_W),
    .T_RCD     (T_RCD),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_RRD     (T_RRD)
  ) u_rules (
    .cmd       (cmd),
    .ba        (ba),
    .ap        (ap_flag),
    .open_vec  (bank_open),
    .act_age   (act_age),
    .close_age (close_age),
    .rrd_age   (rrd_age),
    .err       (err_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_age   <= CNT_SAT;
      err_pulse <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      if (cmd == CMD_ACT)         rrd_age <= CNT_ONE;
      else if (rrd_age != CNT_SAT) rrd_age <= rrd_age + CNT_ONE;
      err_pulse <= (err_now != ERR_NONE);
      err_code  <= err_now;
    end
  end

endmodule

// File: rtl/sdram_bank_monitor_checker.sv
module sdram_bank_monitor_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 cke,
  input logic [BA_W-1:0]      ba,
  input logic                 ap,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 err_pulse,
  input logic [2:0]           err_code
);

  logic taken, is_act, is_pre, is_col;
  assign taken  = !cs_n && cke;
  assign is_act = taken && ({ras_n, cas_n, we_n} == 3'b011);
  assign is_pre = taken && ({ras_n, cas_n, we_n} == 3'b010);
  assign is_col = taken && ras_n && !cas_n;

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !err_pulse);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> bank_open[$past(ba)]);

  p_pre_all_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && ap) |=> (bank_open == '0));

  p_pre_one_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && !ap) |=> !bank_open[$past(ba)]);

  p_closed_column_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !bank_open[ba]) |=> (err_pulse && err_code == 3'd1));

  p_reopen_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && bank_open[ba]) |=> (err_code == 3'd6));

  p_pulse_has_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code != 3'd0));

  p_quiet_no_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_code == 3'd0));

endmodule

bind sdram_bank_monitor sdram_bank_monitor_checker #(
  .NUM_BANKS (NUM_BANKS),
  .BA_W      (BA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .cke       (cke),
  .ba        (ba),
  .ap        (addr[AP_BIT]),
  .bank_open (bank_open),
  .err_pulse (err_pulse),
  .err_code  (err_code)
);

// File: tb/sdram_bank_monitor_test.sv
`timescale 1ns/1ps
module sdram_bank_monitor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  bank_open;
  logic [47:0] open_rows;
  logic        err_pulse;
  logic [2:0]  err_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic       last_pulse;
  logic [2:0] last_code;

  always #2 clk = ~clk;

  sdram_bank_monitor uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .bank_open(bank_open),
    .open_rows(open_rows), .err_pulse(err_pulse), .err_code(err_code)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_err(input string req, input int exp);
    chk(req, {last_pulse, last_code}, {(exp != 0), 3'(exp)});
  endtask

  task automatic step(input logic c, input logic k, input logic [2:0] rcw,
                      input int b, input logic [11:0] a);
    cs_n = c; cke = k; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); addr = a;
    @(negedge clk);
    last_pulse = err_pulse;
    last_code  = err_code;
    cs_n = 1'b1; cke = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 3'b111, 0, 12'h000);
  endtask
  task automatic act(input int b, input logic [11:0] row);
    step(1'b0, 1'b1, 3'b011, b, row);
  endtask
  task automatic rd(input int b, input logic apx);
    step(1'b0, 1'b1, 3'b101, b, {1'b0, apx, 10'h000});
  endtask
  task automatic wr(input int b, input logic apx);
    step(1'b0, 1'b1, 3'b100, b, {1'b0, apx, 10'h000});
  endtask
  task automatic pre(input int b, input logic all);
    step(1'b0, 1'b1, 3'b010, b, {1'b0, all, 10'h000});
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    cs_n = 1'b1; cke = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state
    chk("reset bank_open", bank_open, 0);
    chk("reset err_pulse R11", err_pulse, 0);
    chk("reset err_code R11", err_code, 0);
    chk("reset open_rows", (open_rows == '0), 1);

    // R2: activate opens the bank and captures the row
    act(1, 12'hABC);
    chk_err("R2 act clean", 0);
    chk("R2 bank_open", bank_open, 4'b0010);
    chk("R2 row", open_rows[12 +: 12], 12'hABC);

    // R6 sweep: activate-to-column gap k
    for (int k = 1; k <= 5; k++) begin
      do_reset();
      act(0, 12'h011);
      nop(k - 1);
      if (k[0]) rd(0, 1'b0); else wr(0, 1'b0);
      chk_err($sformatf("R6 gap %0d", k), (k < 3) ? 2 : 0);
    end

    // R7 sweep: activate-to-precharge gap k, single bank; R3 single close
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      act(0, 12'h001);
      nop(1);
      act(1, 12'h002);
      nop(k - 1);
      pre(1, 1'b0);
      chk_err($sformatf("R7 gap %0d", k), (k < 5) ? 3 : 0);
      chk($sformatf("R3 single close gap %0d", k), bank_open, 4'b0001);
    end

    // R8 sweep over act->pre gap p and pre->act gap j; R12 state applied despite error
    for (int p = 1; p <= 7; p++) begin
      for (int j = 1; j <= 7; j++) begin
        do_reset();
        act(1, 12'h100);
        nop(p - 1);
        pre(1, 1'b0);
        chk_err($sformatf("R7 p %0d", p), (p < 5) ? 3 : 0);
        chk($sformatf("R12 closed p %0d", p), bank_open[1], 0);
        nop(j - 1);
        act(1, 12'h200);
        chk_err($sformatf("R8 p %0d j %0d", p, j), ((j < 3) || (p + j < 8)) ? 4 : 0);
        chk($sformatf("R12 reopened p %0d j %0d", p, j), bank_open[1], 1);
      end
    end

    // R9 sweep: activate to another bank
    for (int k = 1; k <= 4; k++) begin
      do_reset();
      act(0, 12'h003);
      nop(k - 1);
      act(2, 12'h004);
      chk_err($sformatf("R9 gap %0d", k), (k < 2) ? 5 : 0);
    end

    // R10: reopen, and priority 6 over 5
    do_reset();
    act(0, 12'h005);
    act(0, 12'h006);
    chk_err("R10 reopen next clock", 6);
    nop(9);
    act(0, 12'h007);
    chk_err("R10 reopen late", 6);
    // R10 priority 4 over 5
    do_reset();
    act(1, 12'h010);
    nop(4);
    pre(1, 1'b0);
    act(2, 12'h020);
    act(1, 12'h030);
    chk_err("R10 priority rp over rrd", 4);

    // R3 precharge all (ba ignored)
    do_reset();
    act(0, 12'h001); nop(1);
    act(1, 12'h002); nop(1);
    act(2, 12'h003); nop(4);
    pre(1, 1'b1);
    chk_err("R3 all clean", 0);
    chk("R3 all closed", bank_open, 0);
    // R7 all-bank form with a young bank
    do_reset();
    act(0, 12'h001); nop(1);
    act(3, 12'h002); nop(1);
    pre(2, 1'b1);
    chk_err("R7 all-bank young", 3);
    chk("R3 all closed young", bank_open, 0);

    // R4 sweep: auto close and the activate that follows
    for (int j = 1; j <= 6; j++) begin
      do_reset();
      act(2, 12'h0F0);
      nop(5);
      rd(2, 1'b1);
      chk_err($sformatf("R4 read ap j %0d", j), 0);
      chk($sformatf("R4 open at cmd j %0d", j), bank_open[2], 1);
      if (j >= 2) begin
        nop(1);
        chk($sformatf("R4 closed j %0d", j), bank_open[2], 0);
        nop(j - 2);
      end
      act(2, 12'h0F1);
      chk_err($sformatf("R4 act j %0d", j), (j == 1) ? 6 : ((j < 4) ? 4 : 0));
    end
    // R4: plain read on the closing edge is legal, then bank is closed
    do_reset();
    act(3, 12'h111);
    nop(3);
    wr(3, 1'b1);
    chk_err("R4 write ap", 0);
    rd(3, 1'b0);
    chk_err("R4 read on closing edge", 0);
    chk("R4 closed after", bank_open[3], 0);
    rd(3, 1'b0);
    chk_err("R5 read after auto close", 1);

    // R5: column to a closed bank
    do_reset();
    rd(3, 1'b0);
    chk_err("R5 read closed", 1);
    wr(2, 1'b1);
    chk_err("R5 write closed", 1);
    chk("R5 no open", bank_open, 0);

    // R1: deselect, clock-enable low, other codes
    do_reset();
    step(1'b1, 1'b1, 3'b011, 0, 12'h055);
    chk_err("R1 deselect act", 0);
    chk("R1 deselect act state", bank_open, 0);
    step(1'b1, 1'b1, 3'b101, 1, 12'h000);
    chk_err("R1 deselect read", 0);
    act(0, 12'h066);
    nop(6);
    step(1'b0, 1'b0, 3'b010, 0, 12'h400);
    chk_err("R1 cke low pre", 0);
    chk("R1 cke low state", bank_open, 4'b0001);
    step(1'b0, 1'b1, 3'b001, 0, 12'h400);
    chk_err("R1 refresh code", 0);
    step(1'b0, 1'b1, 3'b000, 0, 12'h400);
    chk_err("R1 mode code", 0);
    step(1'b0, 1'b1, 3'b110, 0, 12'h400);
    chk_err("R1 stop code", 0);
    chk("R1 state kept", bank_open, 4'b0001);
    chk("R1 row kept", open_rows[11:0], 12'h066);

    // R11: column every clock
    do_reset();
    act(1, 12'h222);
    nop(2);
    for (int i = 0; i < 6; i++) begin
      if (i[0]) wr(1, 1'b0); else rd(1, 1'b0);
      chk_err($sformatf("R11 back to back %0d", i), 0);
    end
    nop(1);
    chk("R11 pulse drops", err_pulse, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule